// File: doc/BRIEF.md
# Byte-wide host mailbox port

This block links an external host to a core through eight data pins. In each direction it moves one 24-bit word at a time, cut into three bytes. The host side is a plain synchronous strobe interface with a 3-bit register address. Each bidirectional pin is split into an input, an output and an output enable. When the host writes the high, middle and low staging bytes, the word lands in a holding register on the core side. A word that the core loads is shown to the host as three readable bytes. Each direction has one flag that acts as its handshake. The host can also post a command that carries an 8-bit vector. That raises a request to the core, which stays up until the core acknowledges it.

A core-side configuration write can switch the eight pins over to general-purpose I/O. In that mode a direction register sets which pins are driven, and host strobes have no effect on any state.

Host register addresses:
- 0: status. Reads bit0 as receive-full, bit1 as transmit-empty and bit2 as command-pending. A write with bit2 set posts a command.
- 1: vector.
- 2, 3 and 4: the high, middle and low data byte. A write goes to the transmit staging byte and a read comes from the receive word.
- 5 to 7: read as zero.

Top module: `byte_mailbox`

## Requirements
- R1: After reset, `pin_oe` is 0 and a status read returns 8'h02 (receive not full, transmit empty, no command). `c_out_ready` is 1, and `host_valid` and `cmd_req` are 0.
- R2: In host mode, `pin_oe` is 8'hFF while `hb_rd` is high and 0 otherwise. During a read, `pin_out` carries the addressed register in the same cycle, and addresses 5 to 7 read 0.
- R3: `c_out_load` while `c_out_ready` is 1 stores `c_out_word` and clears `c_out_ready` on the next cycle. Addresses 2, 3 and 4 then read bits 23:16, 15:8 and 7:0. A load while `c_out_ready` is 0 is ignored.
- R4: A host read of address 4 sets `c_out_ready` (status bit0 clears) on the next cycle.
- R5: A write to address 4 while transmit-empty is set presents {byte at 2, byte at 3, written byte} on `host_word` with `host_valid` high on the next cycle, and clears status bit1.
- R6: Writes to addresses 2, 3 and 4 while transmit-empty is clear are ignored, both for the pending word and for the staged bytes.
- R7: `host_take` while `host_valid` is high drops `host_valid` and sets transmit-empty on the next cycle. A low-byte write in that same cycle is ignored.
- R8: A status write with bit2 set raises `cmd_req` on the next cycle, with `cmd_vec` equal to the vector register. `cmd_ack` clears it. If a set and an ack fall in the same cycle, the set wins.
- R9: A write to address 1 is ignored while a command is pending, and it takes effect once no command is pending.
- R10: A configuration write with `cfg_sel`=0 and bit0=1 selects GPIO mode, `cfg_sel`=1 writes the direction and `cfg_sel`=2 writes the output data. In GPIO mode `pin_oe` equals the direction register, `pin_out` equals the data register, and host strobes change no state. `gpio_in` always follows `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hb_rd | input | 1 | Host read strobe |
| hb_wr | input | 1 | Host write strobe |
| hb_addr | input | 3 | Host register address |
| pin_in | input | 8 | Pin input values (host write data) |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Per-pin output enable |
| host_word | output | 24 | Word received from host |
| host_valid | output | 1 | Host word pending for core |
| host_take | input | 1 | Core takes the host word |
| c_out_word | input | 24 | Word from core to host |
| c_out_load | input | 1 | Core loads a word |
| c_out_ready | output | 1 | Receive bytes free for a new load |
| cmd_req | output | 1 | Host command request |
| cmd_vec | output | 8 | Command vector |
| cmd_ack | input | 1 | Core acknowledges command |
| cfg_we | input | 1 | Configuration write |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| gpio_in | output | 8 | Pin values seen by core |

## Verification
Two pairs of events can fall in the same cycle. In the first, the core takes the host word while the host writes the low byte. The bench drives `host_take` and the address-4 write on the same edge, then expects the flag to show empty and no new word to appear. In the second, the core acknowledges a command in the same cycle that the host posts a new one. The bench drives `cmd_ack` together with a status write and expects `cmd_req` to stay high. The host words themselves are checked by a scoreboard that compares each taken word against the bytes the bench wrote, including bytes that were meant to be ignored.

// File: rtl/byte_mailbox.sv
module byte_mailbox #(
  parameter int BYTE_W = 8,
  parameter int VEC_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hb_rd,
  input  logic                hb_wr,
  input  logic [2:0]          hb_addr,
  input  logic [BYTE_W-1:0]   pin_in,
  output logic [BYTE_W-1:0]   pin_out,
  output logic [BYTE_W-1:0]   pin_oe,
  output logic [3*BYTE_W-1:0] host_word,
  output logic                host_valid,
  input  logic                host_take,
  input  logic [3*BYTE_W-1:0] c_out_word,
  input  logic                c_out_load,
  output logic                c_out_ready,
  output logic                cmd_req,
  output logic [VEC_W-1:0]    cmd_vec,
  input  logic                cmd_ack,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [BYTE_W-1:0]   cfg_wdata,
  output logic [BYTE_W-1:0]   gpio_in
);
  localparam int WORD_W = 3 * BYTE_W;

  logic [WORD_W-1:0] rx_word, hold_word;
  logic [BYTE_W-1:0] tx_hi, tx_mid, ddr, pdr, rdata;
  logic [VEC_W-1:0]  vec;
  logic              rx_full, hold_full, hcmd, gpio_mode;

  wire host_en = !gpio_mode;
  wire wr_en   = host_en && hb_wr;
  wire tx_ok   = wr_en && !hold_full;
  wire rd_lo   = host_en && hb_rd && hb_addr == 3'd4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word   <= '0;
      rx_full   <= 1'b0;
      tx_hi     <= '0;
      tx_mid    <= '0;
      hold_word <= '0;
      hold_full <= 1'b0;
      hcmd      <= 1'b0;
      vec       <= '0;
      gpio_mode <= 1'b0;
      ddr       <= '0;
      pdr       <= '0;
    end else begin
      if (c_out_load && !rx_full) begin
        rx_word <= c_out_word;
        rx_full <= 1'b1;
      end else if (rd_lo) begin
        rx_full <= 1'b0;
      end

      if (tx_ok && hb_addr == 3'd2) tx_hi  <= pin_in;
      if (tx_ok && hb_addr == 3'd3) tx_mid <= pin_in;
      if (tx_ok && hb_addr == 3'd4) begin
        hold_word <= {tx_hi, tx_mid, pin_in};
        hold_full <= 1'b1;
      end else if (host_take) begin
        hold_full <= 1'b0;
      end

      if (wr_en && hb_addr == 3'd0 && pin_in[2]) hcmd <= 1'b1;
      else if (cmd_ack)                          hcmd <= 1'b0;

      if (wr_en && hb_addr == 3'd1 && !hcmd) vec <= pin_in[VEC_W-1:0];

      if (cfg_we) begin
        case (cfg_sel)
          2'd0:    gpio_mode <= cfg_wdata[0];
          2'd1:    ddr       <= cfg_wdata;
          2'd2:    pdr       <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (hb_addr)
      3'd0:    rdata[2:0] = {hcmd, !hold_full, rx_full};
      3'd1:    rdata[VEC_W-1:0] = vec;
      3'd2:    rdata = rx_word[WORD_W-1 -: BYTE_W];
      3'd3:    rdata = rx_word[2*BYTE_W-1 -: BYTE_W];
      3'd4:    rdata = rx_word[BYTE_W-1:0];
      default: rdata = '0;
    endcase
  end

  assign pin_oe      = gpio_mode ? ddr : {BYTE_W{hb_rd}};
  assign pin_out     = gpio_mode ? pdr : rdata;
  assign gpio_in     = pin_in;
  assign host_word   = hold_word;
  assign host_valid  = hold_full;
  assign c_out_ready = !rx_full;
  assign cmd_req     = hcmd;
  assign cmd_vec     = vec;
endmodule

module byte_mailbox_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hb_rd,
  input logic       hb_wr,
  input logic [2:0] hb_addr,
  input logic [7:0] pin_in,
  input logic       gpio_mode,
  input logic       host_valid,
  input logic       host_take,
  input logic       c_out_load,
  input logic       c_out_ready,
  input logic       cmd_req,
  input logic [7:0] cmd_vec,
  input logic       cmd_ack
);
  a_r3_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
    c_out_load && c_out_ready |=> !c_out_ready);

  a_r4_read_drains: assert property (@(posedge clk) disable iff (!rst_n)
    hb_rd && hb_addr == 3'd4 && !gpio_mode && !c_out_load |=> c_out_ready);

  a_r5_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    hb_wr && hb_addr == 3'd4 && !gpio_mode && !host_valid |=> host_valid);

  a_r7_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
    host_take && host_valid |=> !host_valid);

  a_r9_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> (!cmd_req || $stable(cmd_vec)));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack && cmd_req && !(hb_wr && hb_addr == 3'd0 && pin_in[2] && !gpio_mode) |=> !cmd_req);
endmodule

bind byte_mailbox byte_mailbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hb_rd(hb_rd), .hb_wr(hb_wr), .hb_addr(hb_addr),
  .pin_in(pin_in), .gpio_mode(gpio_mode), .host_valid(host_valid),
  .host_take(host_take), .c_out_load(c_out_load), .c_out_ready(c_out_ready),
  .cmd_req(cmd_req), .cmd_vec(cmd_vec), .cmd_ack(cmd_ack)
);

// File: tb/sim_byte_mailbox.sv
module sim_byte_mailbox;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hb_rd = 0, hb_wr = 0, host_take = 0, c_out_load = 0, cmd_ack = 0, cfg_we = 0;
  logic [2:0] hb_addr = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] pin_in = 0, cfg_wdata = 0;
  logic [23:0] c_out_word = 0;
  logic [7:0] pin_out, pin_oe, cmd_vec, gpio_in;
  logic [23:0] host_word;
  logic host_valid, c_out_ready, cmd_req;

  int checks = 0, fails = 0;
  logic [23:0] exp_q[$];

  always #2 clk = ~clk;

  byte_mailbox u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic hwrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk); hb_wr = 1; hb_addr = a; pin_in = d;
    @(negedge clk); hb_wr = 0;
  endtask

  task automatic hread(logic [2:0] a, output logic [7:0] d, output logic [7:0] oe);
    @(negedge clk); hb_rd = 1; hb_addr = a;
    #1; d = pin_out; oe = pin_oe;
    @(negedge clk); hb_rd = 0;
  endtask

  task automatic host_send(logic [23:0] w);
    hwrite(3'd2, w[23:16]); hwrite(3'd3, w[15:8]); hwrite(3'd4, w[7:0]);
    exp_q.push_back(w);
  endtask

  task automatic core_take();
    @(negedge clk); host_take = 1;
    @(negedge clk); host_take = 0;
  endtask

  task automatic cfg(logic [1:0] s, logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  always @(negedge clk) begin
    #1;
    if (host_take && host_valid) begin
      if (exp_q.size() == 0) check("R5 scoreboard empty", 1, 0);
      else check("R5 R6 host word", host_word, exp_q.pop_front());
    end
  end

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] d, oe;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 pin_oe", pin_oe, 0);
    check("R1 ready", c_out_ready, 1);
    check("R1 valid", host_valid, 0);
    check("R1 cmd_req", cmd_req, 0);
    hread(3'd0, d, oe);
    check("R1 status", d, 8'h02);
    check("R2 oe during read", oe, 8'hFF);
    #1; check("R2 oe idle", pin_oe, 0);
    hread(3'd6, d, oe);
    check("R2 unused addr", d, 0);

    host_send(24'hA1B2C3);
    check("R5 valid", host_valid, 1);
    hread(3'd0, d, oe);
    check("R5 status empty clear", d, 8'h00);
    hwrite(3'd2, 8'hFF);
    hwrite(3'd4, 8'h55);
    check("R6 valid kept", host_valid, 1);
    core_take();
    check("R7 valid cleared", host_valid, 0);
    hwrite(3'd3, 8'h11);
    hwrite(3'd4, 8'h22);
    exp_q.push_back(24'hA11122);
    check("R6 staged high kept", host_valid, 1);

    @(negedge clk); host_take = 1; hb_wr = 1; hb_addr = 3'd4; pin_in = 8'h77;
    @(negedge clk); host_take = 0; hb_wr = 0;
    #1;
    check("R7 take vs low write valid", host_valid, 0);
    hread(3'd0, d, oe);
    check("R7 status empty", d, 8'h02);

    @(negedge clk); c_out_word = 24'h123456; c_out_load = 1;
    @(negedge clk); c_out_load = 0;
    #1; check("R3 ready cleared", c_out_ready, 0);
    hread(3'd2, d, oe); check("R3 high byte", d, 8'h12);
    @(negedge clk); c_out_word = 24'h999999; c_out_load = 1;
    @(negedge clk); c_out_load = 0;
    hread(3'd3, d, oe); check("R3 mid byte (load ignored)", d, 8'h34);
    hread(3'd0, d, oe); check("R3 status full", d, 8'h03);
    hread(3'd4, d, oe); check("R3 low byte", d, 8'h56);
    #1; check("R4 ready after low read", c_out_ready, 1);
    hread(3'd0, d, oe); check("R4 status", d, 8'h02);

    hwrite(3'd1, 8'h5A);
    hwrite(3'd0, 8'h04);
    #1; check("R8 cmd_req", cmd_req, 1);
    check("R8 cmd_vec", cmd_vec, 8'h5A);
    hwrite(3'd1, 8'h33);
    #1; check("R9 vector held", cmd_vec, 8'h5A);
    @(negedge clk); cmd_ack = 1; hb_wr = 1; hb_addr = 3'd0; pin_in = 8'h04;
    @(negedge clk); cmd_ack = 0; hb_wr = 0;
    #1; check("R8 set beats ack", cmd_req, 1);
    @(negedge clk); cmd_ack = 1;
    @(negedge clk); cmd_ack = 0;
    #1; check("R8 ack clears", cmd_req, 0);
    hwrite(3'd1, 8'h33);
    hread(3'd1, d, oe); check("R9 vector write after clear", d, 8'h33);

    cfg(2'd1, 8'h0F);
    cfg(2'd2, 8'hA5);
    cfg(2'd0, 8'h01);
    #1;
    check("R10 oe = direction", pin_oe, 8'h0F);
    check("R10 out = data", pin_out, 8'hA5);
    @(negedge clk); pin_in = 8'h3C; #1;
    check("R10 gpio_in", gpio_in, 8'h3C);
    @(negedge clk); hb_rd = 1; hb_addr = 3'd0; #1;
    check("R10 read strobe ignored", pin_oe, 8'h0F);
    @(negedge clk); hb_rd = 0;
    hwrite(3'd1, 8'hEE);
    hwrite(3'd4, 8'h01);
    #1; check("R10 low write ignored", host_valid, 0);
    cfg(2'd0, 8'h00);
    hread(3'd1, d, oe); check("R10 vector untouched", d, 8'h33);
    check("R10 scoreboard drained", exp_q.size(), 0);

    finish_up();
  end
endmodule